// File: doc/BRIEF.md
# Challenge-Response Authentication Command Controller

This block is the command front end of an authentication token. A serial link layer delivers command and data bytes as a valid/ready byte stream. The controller stores a 64-bit challenge and starts MAC computations on an attached hash engine, in a form that either omits or includes the device identifier. It then returns the 160-bit result as a bit stream under a valid/ready handshake.

A compute command does not start the engine at once. The controller first waits a fixed, parameterised delay (the default is 100 µs at the configured clock), so the host has time to prepare the supply. When the engine reports completion, the controller captures the result and clears the stored challenge. It then waits for a single zero preamble byte before it releases the MAC bits. A link reset pulse ends any transaction. A command ends with the 160th bit or with a link reset, and the challenge write also ends only through a link reset.

Top module: `auth_cmd_ctrl`

## Requirements
- R1: After reset, `rx_ready` is 1, `hash_start` and `tx_valid` are 0, `chal_ovf` is 0 and `hash_challenge` is zero.
- R2: In idle, byte 0Ch opens a challenge write. The next 8 accepted bytes load `hash_challenge`, with byte k (counting from 0) at bits 8k+7..8k, so the first byte is the least significant. The write stays open until a link reset.
- R3: While a challenge write is open, accepted bytes after the eighth are discarded, leave `hash_challenge` unchanged and set `chal_ovf`. `chal_ovf` holds until the next 0Ch opcode is accepted, which clears it.
- R4: In idle, opcode 35h starts a computation with `hash_use_id` = 1 and opcode 36h starts one with `hash_use_id` = 0. The value holds while `hash_start` is high.
- R5: `hash_start` is a one-cycle pulse. It is high in the DELAY_CYC-th cycle after the cycle in which the compute opcode is accepted, where DELAY_CYC = CLK_MHZ × START_US.
- R6: Bytes offered during the delay or the computation are accepted and have no effect on the challenge or on the start timing.
- R7: When `hash_done` is seen during a computation, `hash_mac` is captured and `hash_challenge` becomes zero, so a compute issued without a new write uses a zero challenge.
- R8: After completion, the next accepted byte is the preamble. A value of 00h opens the readback. Any other value returns the controller to idle with no readback.
- R9: During readback `tx_valid` is 1 and `tx_bit` shows the captured MAC least significant bit first. A bit advances only when `tx_ready` is 1. The bit holds while `tx_ready` is 0. After the 160th transfer `tx_valid` falls and the controller is idle.
- R10: In idle, a byte other than 0Ch, 35h or 36h is consumed and leaves the controller idle, with the challenge and `chal_ovf` unchanged.
- R11: A `link_rst` pulse returns the controller to idle from any state, without changing `hash_challenge` or `chal_ovf`.
- R12: `rx_ready` is 0 during readback and 1 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_rst | input | 1 | Link reset pulse that ends any transaction |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Controller accepts a byte |
| hash_start | output | 1 | One-cycle start pulse to the hash engine |
| hash_use_id | output | 1 | Include the device identifier in the computation |
| hash_challenge | output | 64 | Stored challenge |
| hash_done | input | 1 | Hash engine completion pulse |
| hash_mac | input | 160 | Hash engine result, valid with `hash_done` |
| chal_ovf | output | 1 | Sticky flag set when a challenge write is too long |
| tx_valid | output | 1 | MAC bit available |
| tx_bit | output | 1 | Current MAC bit |
| tx_ready | input | 1 | Host takes the current bit |

## Verification
A behavioural reference model runs in step with the design and compares every output on every clock. It is driven with these sequences:
- A clean write followed by a compute that omits the identifier, with stray bytes during the delay. This separates ignored bytes from challenge writes and measures the exact start latency.
- A compute that includes the identifier, issued without a new write. This distinguishes the two opcodes and shows whether the challenge was consumed.
- An overlong write, an unknown opcode and a nonzero preamble. These probe the overflow flag's lifetime and the abort paths.
- A readback with irregular `tx_ready` stalls, and a readback cut short by a link reset. These separate correct bit order and holding from early or skipped shifts.

// File: rtl/auth_cmd_ctrl.sv
module auth_cmd_ctrl #(
  parameter int CLK_MHZ     = 200,
  parameter int START_US    = 100,
  parameter int CHAL_BYTES  = 8,
  parameter int MAC_BITS    = 160,
  parameter logic [7:0] OP_WRITE    = 8'h0C,
  parameter logic [7:0] OP_MAC_ID   = 8'h35,
  parameter logic [7:0] OP_MAC_NOID = 8'h36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    link_rst,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  output logic                    rx_ready,
  output logic                    hash_start,
  output logic                    hash_use_id,
  output logic [8*CHAL_BYTES-1:0] hash_challenge,
  input  logic                    hash_done,
  input  logic [MAC_BITS-1:0]     hash_mac,
  output logic                    chal_ovf,
  output logic                    tx_valid,
  output logic                    tx_bit,
  input  logic                    tx_ready
);
  localparam int DELAY_CYC = CLK_MHZ * START_US;
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam int IW = $clog2(CHAL_BYTES + 1);
  localparam int BW = $clog2(MAC_BITS);

  typedef enum logic [2:0] {ST_IDLE, ST_CHAL, ST_DLY, ST_COMP, ST_PRE, ST_READ} st_t;

  st_t                    st;
  logic [CW-1:0]          dly_cnt;
  logic [IW-1:0]          byte_idx;
  logic [BW-1:0]          bit_cnt;
  logic [MAC_BITS-1:0]    mac_sr;
  logic                   take;

  assign rx_ready   = (st != ST_READ);
  assign take       = rx_valid && rx_ready;
  assign hash_start = (st == ST_DLY) && (dly_cnt == CW'(DELAY_CYC - 1));
  assign tx_valid   = (st == ST_READ);
  assign tx_bit     = mac_sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= ST_IDLE;
      dly_cnt        <= '0;
      byte_idx       <= '0;
      bit_cnt        <= '0;
      mac_sr         <= '0;
      hash_challenge <= '0;
      hash_use_id    <= 1'b0;
      chal_ovf       <= 1'b0;
    end else if (link_rst) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          if (rx_data == OP_WRITE) begin
            st       <= ST_CHAL;
            byte_idx <= '0;
            chal_ovf <= 1'b0;
          end else if (rx_data == OP_MAC_ID || rx_data == OP_MAC_NOID) begin
            st          <= ST_DLY;
            dly_cnt     <= '0;
            hash_use_id <= (rx_data == OP_MAC_ID);
          end
        end
        ST_CHAL: if (take) begin
          if (byte_idx < IW'(CHAL_BYTES)) begin
            hash_challenge[{byte_idx, 3'b000} +: 8] <= rx_data;
            byte_idx <= byte_idx + 1'b1;
          end else begin
            chal_ovf <= 1'b1;
          end
        end
        ST_DLY: begin
          if (hash_start) st <= ST_COMP;
          else dly_cnt <= dly_cnt + 1'b1;
        end
        ST_COMP: if (hash_done) begin
          mac_sr         <= hash_mac;
          hash_challenge <= '0;
          st             <= ST_PRE;
        end
        ST_PRE: if (take) begin
          st      <= (rx_data == 8'h00) ? ST_READ : ST_IDLE;
          bit_cnt <= '0;
        end
        ST_READ: if (tx_ready) begin
          mac_sr <= mac_sr >> 1;
          if (bit_cnt == BW'(MAC_BITS - 1)) st <= ST_IDLE;
          else bit_cnt <= bit_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module auth_cmd_chk #(parameter int CW = 64) (
  input logic          clk,
  input logic          rst_n,
  input logic          link_rst,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          hash_start,
  input logic          hash_done,
  input logic [CW-1:0] hash_challenge,
  input logic          chal_ovf,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          tx_bit
);
  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |=> !hash_start);
  // R12
  ready_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);
  // R11
  link_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst |=> (!tx_valid && !hash_start));
  // R9
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !link_rst) |=> (tx_valid && $stable(tx_bit)));
  // R2
  chal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rx_valid && rx_ready) && !hash_done) |=> $stable(hash_challenge));
  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chal_ovf && !(rx_valid && rx_ready)) |=> chal_ovf);
endmodule

bind auth_cmd_ctrl auth_cmd_chk #(.CW(8*CHAL_BYTES)) i_chk (
  .clk(clk), .rst_n(rst_n), .link_rst(link_rst), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .hash_start(hash_start), .hash_done(hash_done),
  .hash_challenge(hash_challenge), .chal_ovf(chal_ovf), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_bit(tx_bit));

// File: tb/test_auth_cmd_ctrl.sv
module test_auth_cmd_ctrl;
  localparam int D = 200;
  logic clk = 1'b0, rst_n = 1'b0, link_rst = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b0, hash_done = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [159:0] hash_mac = '0;
  logic rx_ready, hash_start, hash_use_id, chal_ovf, tx_valid, tx_bit;
  logic [63:0] hash_challenge;

  auth_cmd_ctrl #(.CLK_MHZ(200), .START_US(1)) i_auth_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .link_rst(link_rst), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .hash_start(hash_start),
    .hash_use_id(hash_use_id), .hash_challenge(hash_challenge),
    .hash_done(hash_done), .hash_mac(hash_mac), .chal_ovf(chal_ovf),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model
  int mph = 0, mi = 0, mc = 0, mb = 0;
  logic [63:0] mchal = '0;
  logic [159:0] mmac = '0;
  logic movf = 1'b0, muse = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mchal = '0; movf = 0; muse = 0; mmac = '0;
    end else if (link_rst) mph = 0;
    else case (mph)
      0: if (rx_valid) begin
           if (rx_data == 8'h0C) begin mph = 1; mi = 0; movf = 0; end
           else if (rx_data == 8'h35 || rx_data == 8'h36) begin
             mph = 2; mc = 0; muse = (rx_data == 8'h35);
           end
         end
      1: if (rx_valid) begin
           if (mi < 8) begin mchal[mi*8 +: 8] = rx_data; mi++; end
           else movf = 1;
         end
      2: if (mc == D-1) mph = 3; else mc++;
      3: if (hash_done) begin mmac = hash_mac; mchal = '0; mph = 4; end
      4: if (rx_valid) begin mph = (rx_data == 8'h00) ? 5 : 0; mb = 0; end
      5: if (tx_ready) begin mb++; if (mb == 160) mph = 0; end
      default: mph = 0;
    endcase
  end

  always @(negedge clk) if (rst_n) begin
    chk(rx_ready == (mph != 5), "R12 model rx_ready", 160'(rx_ready), 160'(mph != 5));
    chk(hash_start == (mph == 2 && mc == D-1), "R5 model hash_start", 160'(hash_start), 160'(mph == 2 && mc == D-1));
    chk(hash_use_id == muse, "R4 model use_id", 160'(hash_use_id), 160'(muse));
    chk(hash_challenge == mchal, "R2 model challenge", 160'(hash_challenge), 160'(mchal));
    chk(chal_ovf == movf, "R3 model overflow", 160'(chal_ovf), 160'(movf));
    chk(tx_valid == (mph == 5), "R9 model tx_valid", 160'(tx_valid), 160'(mph == 5));
    if (mph == 5) chk(tx_bit == mmac[mb], "R9 model tx_bit", 160'(tx_bit), 160'(mmac[mb]));
  end

  // hash engine model
  int eng = 0;
  logic [63:0] st_chal = '0;
  logic st_use = 1'b0;
  always @(negedge clk) begin
    hash_done <= 1'b0;
    if (eng > 0) begin
      eng--;
      if (eng == 0) hash_done <= 1'b1;
    end
    if (hash_start) begin
      eng = 6;
      st_chal = hash_challenge;
      st_use = hash_use_id;
      hash_mac <= {hash_challenge, ~hash_challenge, 31'h2B3C4D5E, hash_use_id};
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic pulse_link();
    @(negedge clk); link_rst = 1'b1;
    @(negedge clk); link_rst = 1'b0;
  endtask
  task automatic compute(input logic [7:0] op, input bit noise);
    int k;
    @(negedge clk); rx_valid = 1'b1; rx_data = op;
    k = 0;
    while (k < 2*D) begin
      @(negedge clk); k++;
      rx_valid = noise && (k < 12);
      rx_data = 8'h0C + 8'(k);
      if (hash_start) break;
    end
    rx_valid = 1'b0;
    chk(k == D, "R5 start latency", 160'(k), 160'(D));
    repeat (10) @(negedge clk);
    chk(hash_challenge == 64'h0, "R7 challenge consumed", 160'(hash_challenge), 160'h0);
  endtask
  task automatic read_mac(input int limit, output logic [159:0] got, output int n);
    int cyc = 0;
    n = 0; got = '0;
    while (n < limit && cyc < 1000) begin
      @(negedge clk); cyc++;
      tx_ready = (cyc % 3 != 0);
      if (tx_valid && tx_ready) begin got[n] = tx_bit; n++; end
      if (tx_valid && n == 5) chk(rx_ready == 1'b0, "R12 not ready in readback", 160'(rx_ready), 160'h0);
    end
    @(negedge clk); tx_ready = 1'b0;
  endtask

  initial begin
    logic [159:0] got;
    int n;
    repeat (3) @(negedge clk);
    chk(rx_ready && !hash_start && !tx_valid && !chal_ovf && hash_challenge == 0, "R1 reset state",
        {rx_ready, hash_start, tx_valid, chal_ovf, hash_challenge}, {4'b1000, 64'h0});
    rst_n = 1'b1;
    send(8'h0C);
    for (int i = 0; i < 8; i++) send(8'h11 * 8'(i + 1));
    chk(hash_challenge == 64'h8877665544332211, "R2 challenge byte order", 160'(hash_challenge), 160'h8877665544332211);
    pulse_link();
    compute(8'h36, 1'b1);
    chk(st_use == 1'b0, "R4 36h omits identifier", 160'(st_use), 160'h0);
    chk(st_chal == 64'h8877665544332211, "R6 noise ignored", 160'(st_chal), 160'h8877665544332211);
    send(8'h00);
    read_mac(160, got, n);
    chk(got == {st_chal, ~st_chal, 31'h2B3C4D5E, st_use}, "R9 MAC lsb first", got, {st_chal, ~st_chal, 31'h2B3C4D5E, st_use});
    chk(!tx_valid && rx_ready, "R9 idle after 160 bits", 160'(tx_valid), 160'h0);
    compute(8'h35, 1'b0);
    chk(st_use == 1'b1, "R4 35h includes identifier", 160'(st_use), 160'h1);
    chk(st_chal == 64'h0, "R7 compute without rewrite", 160'(st_chal), 160'h0);
    send(8'h5A);
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R8 nonzero preamble aborts", 160'(tx_valid), 160'h0);
    send(8'h0C);
    for (int i = 0; i < 10; i++) send(8'hA0 + 8'(i));
    chk(chal_ovf == 1'b1, "R3 overflow set", 160'(chal_ovf), 160'h1);
    chk(hash_challenge == 64'hA7A6A5A4A3A2A1A0, "R3 extra bytes dropped", 160'(hash_challenge), 160'hA7A6A5A4A3A2A1A0);
    pulse_link();
    chk(chal_ovf == 1'b1, "R11 link keeps overflow", 160'(chal_ovf), 160'h1);
    send(8'hAA);
    chk(chal_ovf == 1'b1 && hash_challenge == 64'hA7A6A5A4A3A2A1A0, "R10 unknown opcode", 160'(hash_challenge), 160'hA7A6A5A4A3A2A1A0);
    send(8'h0C);
    chk(chal_ovf == 1'b0, "R3 overflow cleared by write", 160'(chal_ovf), 160'h0);
    for (int i = 0; i < 8; i++) send(8'h3C ^ 8'(i));
    pulse_link();
    compute(8'h35, 1'b0);
    send(8'h00);
    read_mac(20, got, n);
    pulse_link();
    chk(!tx_valid && rx_ready, "R11 link aborts readback", 160'(tx_valid), 160'h0);
    send(8'h0C);
    chk(chal_ovf == 1'b0 && rx_ready, "R11 idle accepts command", 160'(rx_ready), 160'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule